// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing fields of an operand descriptor into a memory address for a 16-bit processor with segmented memory. On each accepted request it decodes the 2-bit mode field and the 3-bit register/memory field. It picks the base and index register values that the fields name and adds a displacement of the width the mode calls for. The 16-bit sum is the effective offset.

The block then chooses a segment register. The default follows the addressing form, and an override request can replace it. The chosen segment value is shifted left four places and added to the offset, which gives a 20-bit physical address. The block also reports, as a 2-bit code, which segment it used. A descriptor that names a register operand produces no address; the block raises a register-operand flag instead.

All results are registered, so the answer appears one clock cycle after the request. Instruction fetch, prefetch buffering and bus cycles belong to the blocks around this one.

Top module: `seg_ea_unit`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_regop`, `out_seg`, `out_offset` and `out_phys` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: The register/memory field `rm` selects the address terms as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX. The offset is the sum of these terms and the displacement.
- R4: When there is no override, the segment is stack (`out_seg` = 01) for `rm` 2, 3 and 6, and data (`out_seg` = 11) for all other `rm` values. Mode 0 with `rm` 6 is the exception and uses the data segment (see R5).
- R5: Mode 0 (`mode` = 00) adds no displacement. The one exception is `rm` = 6, where the offset is the full 16-bit `disp` alone and no register is added.
- R6: Mode 1 (`mode` = 01) adds `disp[7:0]` sign-extended to 16 bits. Bits `disp[15:8]` have no effect.
- R7: Mode 2 (`mode` = 10) adds all 16 bits of `disp`.
- R8: Mode 3 (`mode` = 11) sets `out_regop` to 1 and drives `out_offset`, `out_phys` and `out_seg` to zero.
- R9: When `ovr_en` is 1 on a memory operand, `out_seg` equals `ovr_sel` and that segment is used. The segment codes are 00 = ES, 01 = SS, 10 = CS and 11 = DS.
- R10: `out_phys` equals (segment value × 16 + offset) modulo 2^20.
- R11: The offset sum wraps modulo 2^16.
- R12: While `in_valid` is low, the result outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | Addressing mode field |
| rm | input | 3 | Register/memory field |
| disp | input | 16 | Displacement or direct address |
| reg_bx | input | 16 | BX base register value |
| reg_bp | input | 16 | BP base register value |
| reg_si | input | 16 | SI index register value |
| reg_di | input | 16 | DI index register value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override requested |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Result valid |
| out_regop | output | 1 | Descriptor names a register operand |
| out_seg | output | 2 | Code of the segment used |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |

## Verification
Each fault has a distinct signature at the ports, and it shows in the cycle after the request:

- A wrong term decode shows as an offset off by a whole register value.
- A wrong default-segment decision changes `out_seg` and shifts `out_phys` by the difference between two segment bases times 16.
- A displacement sized for the wrong mode changes the offset by the upper displacement byte or by the sign bit.
- A pipeline register that loads while idle breaks the held values in the cycle after an idle request.

The bench chooses register and segment values that are far apart so that these signatures stay distinct. It also covers both wrap-around cases: the offset wrapping modulo 2^16 and the physical address wrapping modulo 2^20.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int OFS_W = 16;
    localparam int SHIFT = 4;
    localparam int PA_W  = OFS_W + SHIFT;

    typedef logic [OFS_W-1:0] word_t;
    typedef logic [PA_W-1:0]  phys_t;

    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_SS = 2'b01,
        SEG_CS = 2'b10,
        SEG_DS = 2'b11
    } seg_code_e;

    typedef enum logic [1:0] {
        MOD_NODISP = 2'b00,
        MOD_D8     = 2'b01,
        MOD_D16    = 2'b10,
        MOD_REG    = 2'b11
    } mod_e;

    typedef struct packed {
        word_t     term_a;
        word_t     term_b;
        word_t     term_d;
        seg_code_e seg;
        logic      regop;
    } ea_terms_t;

    typedef struct packed {
        logic      regop;
        seg_code_e seg;
        word_t     offset;
        phys_t     phys;
    } ea_result_t;

    function automatic word_t sext_byte(input logic [7:0] b);
        return {{(OFS_W-8){b[7]}}, b};
    endfunction

    function automatic logic rm_is_stack(input logic [2:0] rm);
        return (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6);
    endfunction
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [2:0] rm,
    input  word_t      disp,
    input  word_t      reg_bx,
    input  word_t      reg_bp,
    input  word_t      reg_si,
    input  word_t      reg_di,
    output ea_terms_t  terms
);
    mod_e      m;
    word_t     a, b, d;
    logic      stk;
    logic      regop;

    assign m = mod_e'(mode);

    always_comb begin
        a = '0;
        b = '0;
        unique case (rm)
            3'd0: begin a = reg_bx; b = reg_si; end
            3'd1: begin a = reg_bx; b = reg_di; end
            3'd2: begin a = reg_bp; b = reg_si; end
            3'd3: begin a = reg_bp; b = reg_di; end
            3'd4: a = reg_si;
            3'd5: a = reg_di;
            3'd6: a = reg_bp;
            default: a = reg_bx;
        endcase
        stk   = rm_is_stack(rm);
        regop = 1'b0;
        d     = '0;
        unique case (m)
            MOD_NODISP: begin
                if (rm == 3'd6) begin
                    a   = '0;
                    b   = '0;
                    d   = disp;
                    stk = 1'b0;
                end
            end
            MOD_D8:  d = sext_byte(disp[7:0]);
            MOD_D16: d = disp;
            default: regop = 1'b1;
        endcase
        terms.term_a = a;
        terms.term_b = b;
        terms.term_d = d;
        terms.seg    = stk ? SEG_SS : SEG_DS;
        terms.regop  = regop;
    end
endmodule

// File: rtl/ea_seg_select.sv
module ea_seg_select
    import ea_pkg::*;
(
    input  seg_code_e  dflt,
    input  logic       ovr_en,
    input  logic [1:0] ovr_sel,
    input  word_t      seg_es,
    input  word_t      seg_cs,
    input  word_t      seg_ss,
    input  word_t      seg_ds,
    output seg_code_e  code,
    output word_t      base
);
    assign code = ovr_en ? seg_code_e'(ovr_sel) : dflt;

    always_comb begin
        unique case (code)
            SEG_ES:  base = seg_es;
            SEG_SS:  base = seg_ss;
            SEG_CS:  base = seg_cs;
            default: base = seg_ds;
        endcase
    end
endmodule

// File: rtl/ea_adder.sv
module ea_adder
    import ea_pkg::*;
(
    input  ea_terms_t  terms,
    input  seg_code_e  code,
    input  word_t      base,
    output ea_result_t res
);
    word_t offset;
    phys_t seg_ext;
    phys_t off_ext;

    assign offset  = terms.term_a + terms.term_b + terms.term_d;
    assign seg_ext = {base, {SHIFT{1'b0}}};
    assign off_ext = {{SHIFT{1'b0}}, offset};

    always_comb begin
        res = '0;
        res.regop = terms.regop;
        if (!terms.regop) begin
            res.seg    = code;
            res.offset = offset;
            res.phys   = seg_ext + off_ext;
        end
    end
endmodule

// File: rtl/seg_ea_unit.sv
module seg_ea_unit
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  mode,
    input  logic [2:0]  rm,
    input  logic [15:0] disp,
    input  logic [15:0] reg_bx,
    input  logic [15:0] reg_bp,
    input  logic [15:0] reg_si,
    input  logic [15:0] reg_di,
    input  logic [15:0] seg_es,
    input  logic [15:0] seg_cs,
    input  logic [15:0] seg_ss,
    input  logic [15:0] seg_ds,
    input  logic        ovr_en,
    input  logic [1:0]  ovr_sel,
    output logic        out_valid,
    output logic        out_regop,
    output logic [1:0]  out_seg,
    output logic [15:0] out_offset,
    output logic [19:0] out_phys
);
    ea_terms_t  terms;
    seg_code_e  code;
    word_t      base;
    ea_result_t comb_res;
    ea_result_t res_q;
    logic       vld_q;

    ea_mode_decode u_dec (
        .mode(mode), .rm(rm), .disp(disp),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .terms(terms)
    );

    ea_seg_select u_seg (
        .dflt(terms.seg), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .code(code), .base(base)
    );

    ea_adder u_add (
        .terms(terms), .code(code), .base(base), .res(comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= comb_res;
        end
    end

    assign out_valid  = vld_q;
    assign out_regop  = res_q.regop;
    assign out_seg    = res_q.seg;
    assign out_offset = res_q.offset;
    assign out_phys   = res_q.phys;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_regop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_regop) |-> (out_offset == '0 && out_phys == '0 && out_seg == 2'b00));
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_offset) && $stable(out_phys) && $stable(out_seg)));
    assert_override_seg_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ovr_en && mode != 2'b11) |=> (out_seg == $past(ovr_sel)));
    assert_default_stack_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ovr_en && mode != 2'b11 && (rm == 3'd2 || rm == 3'd3 || (rm == 3'd6 && mode != 2'b00)))
        |=> (out_seg == 2'b01));
endmodule

// File: tb/sim_seg_ea_unit.sv
module sim_seg_ea_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic [2:0]  rm = '0;
    logic [15:0] disp = '0;
    logic [15:0] reg_bx = 16'h0300, reg_bp = 16'h0700, reg_si = 16'h0200, reg_di = 16'h0400;
    logic [15:0] seg_es = 16'h3000, seg_cs = 16'h5000, seg_ss = 16'h0100, seg_ds = 16'h0200;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        out_valid, out_regop;
    logic [1:0]  out_seg;
    logic [15:0] out_offset;
    logic [19:0] out_phys;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    seg_ea_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .rm(rm), .disp(disp),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .out_valid(out_valid), .out_regop(out_regop), .out_seg(out_seg),
        .out_offset(out_offset), .out_phys(out_phys)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] seg_val(input logic [1:0] c);
        case (c)
            2'b00: return seg_es;
            2'b01: return seg_ss;
            2'b10: return seg_cs;
            default: return seg_ds;
        endcase
    endfunction

    // Drive one request at a falling edge; results are registered at the next rising edge.
    task automatic issue(input logic [1:0] m, input logic [2:0] r, input logic [15:0] d,
                         input logic oe, input logic [1:0] os);
        @(negedge clk);
        mode = m; rm = r; disp = d; ovr_en = oe; ovr_sel = os; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_mem(input string req, input logic [15:0] eo, input logic [1:0] es);
        logic [19:0] ep;
        ep = {seg_val(es), 4'h0} + {4'h0, eo};
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " regop"}, 32'(out_regop), 32'd0);
        chk({req, " offset"}, 32'(out_offset), 32'(eo));
        chk({req, " seg"}, 32'(out_seg), 32'(es));
        chk({req, " phys"}, 32'(out_phys), 32'(ep));
    endtask

    task automatic t_reset;
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 regop", 32'(out_regop), 0);
        chk("R1 seg", 32'(out_seg), 0);
        chk("R1 offset", 32'(out_offset), 0);
        chk("R1 phys", 32'(out_phys), 0);
    endtask

    task automatic t_worked_examples;
        issue(2'b10, 3'd5, 16'h0250, 1'b0, 2'b00);
        expect_mem("R7 di+disp", 16'h0650, 2'b11);
        chk("R10 di+disp phys", 32'(out_phys), 32'h02650);
        issue(2'b00, 3'd0, 16'hFFFF, 1'b0, 2'b00);
        expect_mem("R3 bx+si", 16'h0500, 2'b11);
        chk("R10 bx+si phys", 32'(out_phys), 32'h02500);
    endtask

    task automatic t_all_rm;
        for (int r = 0; r < 8; r++) begin
            logic [15:0] eo;
            logic [1:0]  es;
            case (r)
                0: eo = reg_bx + reg_si;
                1: eo = reg_bx + reg_di;
                2: eo = reg_bp + reg_si;
                3: eo = reg_bp + reg_di;
                4: eo = reg_si;
                5: eo = reg_di;
                6: eo = reg_bp;
                default: eo = reg_bx;
            endcase
            es = (r == 2 || r == 3 || r == 6) ? 2'b01 : 2'b11;
            issue(2'b10, 3'(r), 16'h0010, 1'b0, 2'b00);
            expect_mem("R3 R4 mode2 table", eo + 16'h0010, es);
        end
    endtask

    task automatic t_direct;
        issue(2'b00, 3'd6, 16'h1234, 1'b0, 2'b00);
        expect_mem("R5 direct", 16'h1234, 2'b11);
        chk("R5 direct phys", 32'(out_phys), 32'h03234);
    endtask

    task automatic t_disp8;
        issue(2'b01, 3'd7, 16'hAB80, 1'b0, 2'b00);
        expect_mem("R6 negative byte", 16'h0280, 2'b11);
        issue(2'b01, 3'd6, 16'hFF05, 1'b0, 2'b00);
        expect_mem("R6 positive byte", 16'h0705, 2'b01);
    endtask

    task automatic t_regop;
        issue(2'b11, 3'd2, 16'h1111, 1'b1, 2'b10);
        chk("R8 valid", 32'(out_valid), 1);
        chk("R8 regop", 32'(out_regop), 1);
        chk("R8 offset", 32'(out_offset), 0);
        chk("R8 phys", 32'(out_phys), 0);
        chk("R8 seg", 32'(out_seg), 0);
    endtask

    task automatic t_override;
        issue(2'b00, 3'd2, 16'h0000, 1'b1, 2'b10);
        expect_mem("R9 stack form to CS", 16'h0900, 2'b10);
        issue(2'b00, 3'd6, 16'h0042, 1'b1, 2'b00);
        expect_mem("R9 direct to ES", 16'h0042, 2'b00);
        issue(2'b01, 3'd4, 16'h0001, 1'b1, 2'b01);
        expect_mem("R9 data form to SS", 16'h0201, 2'b01);
    endtask

    task automatic t_wraps;
        reg_bx = 16'hFFF0; reg_si = 16'h0020;
        issue(2'b00, 3'd0, 16'h0000, 1'b0, 2'b00);
        expect_mem("R11 offset wrap", 16'h0010, 2'b11);
        seg_ds = 16'hFFFF;
        issue(2'b00, 3'd6, 16'h0020, 1'b0, 2'b00);
        chk("R10 phys wrap", 32'(out_phys), 32'h00010);
        reg_bx = 16'h0300; reg_si = 16'h0200; seg_ds = 16'h0200;
    endtask

    task automatic t_hold;
        issue(2'b10, 3'd1, 16'h0004, 1'b0, 2'b00);
        expect_mem("R12 setup", 16'h0704, 2'b11);
        @(negedge clk);
        mode = 2'b00; rm = 3'd3; disp = 16'h9999; ovr_en = 1'b1; ovr_sel = 2'b10;
        @(negedge clk);
        chk("R2 idle valid", 32'(out_valid), 0);
        chk("R12 held offset", 32'(out_offset), 32'h0704);
        chk("R12 held seg", 32'(out_seg), 32'b11);
        chk("R12 held phys", 32'(out_phys), 32'h02704);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_worked_examples();
        t_all_rm();
        t_direct();
        t_disp8();
        t_regop();
        t_override();
        t_wraps();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule